// File: doc/BRIEF.md
# Dual-Sided Mailbox

This block lets two processors that share one clock pass 32-bit words to each other. It has a fixed number of one-way channels. Each channel has a small FIFO, and the sending side is chosen per channel by a parameter. Each processor reaches the block through its own simple register port. A write to a channel's data register from the sending side enqueues a word. A read of that register from the receiving side dequeues the oldest word.

Each side has its own interrupt-enable and interrupt-status words. Both sides decode the same address map, mirrored:
- 0x60 and 0x70 are the accessing side's own enable and status.
- 0x40 and 0x50 are a read-only view of the other side's enable and status.

In the status words, channel n owns two bits:
- bit 2n is receive-pending. It is sticky and cleared by writing a one.
- bit 2n+1 is transmit-space. It is a live flag.

A sender learns that its message was consumed by reading the peer view at 0x50 and finding the receive bit for its channel at zero. Each side has an interrupt line that is raised whenever one of its status bits is both set and enabled.

The channel count may be at most 16. Accesses whose byte address is not word aligned are ignored.

Top module: `mailbox_dual`

## Requirements
- R1: After reset every FIFO is empty, both enable words are zero, both interrupt lines are low and both read-data outputs are zero.
- R2: A write to the data register at 0x180+4n from the side that sends on channel n enqueues the word. Each read of that register from the other side returns the oldest word held and removes it, in first-in first-out order, up to DEPTH words.
- R3: Channel n's count register at 0x140+4n returns, in bits [2:0], the number of words held. Its FIFO status register at 0x100+4n returns 1 in bit 0 when the FIFO is full. Both registers are readable from either side.
- R4: A data write to a full FIFO is dropped. A data read of an empty FIFO returns zero and changes nothing.
- R5: When a full FIFO sees an enqueue and a dequeue in the same cycle, both are accepted, the oldest word is returned and the count stays at DEPTH.
- R6: A data write from the receiving side of a channel and a data read from its sending side have no effect, and the read returns zero.
- R7: In a status word, bit 2n is the receive-pending bit for channel n and bit 2n+1 is its transmit-space bit. On the receiving side, receive-pending becomes set one cycle after the FIFO is non-empty. On the sending side, transmit-space reads 1 while the FIFO is not full. Bits for the direction a side does not use read 0.
- R8: Receive-pending stays set until that side writes a one to it at its status address (0x70) while the FIFO is empty. Writing zero bits, or writing to the transmit-space bits, changes nothing.
- R9: Offsets 0x60 and 0x70 address the accessing side's own enable and status. Offsets 0x40 and 0x50 read back the other side's enable and status. Writes to 0x40 and 0x50 are ignored.
- R10: Each side's interrupt output is high exactly when some bit is set in both that side's status and its enable.
- R11: The LOCAL_SENDS parameter gives the direction of each channel: bit n at 1 means the local port sends on channel n. By default the local port sends on the even channels and the remote port sends on the odd channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| loc_sel | input | 1 | Local port access request |
| loc_wr | input | 1 | Local port write (1) or read (0) |
| loc_addr | input | 9 | Local port byte address |
| loc_wdata | input | DW | Local port write data |
| loc_rdata | output | DW | Local port read data, valid the cycle after the read |
| loc_irq | output | 1 | Local side interrupt |
| rem_sel | input | 1 | Remote port access request |
| rem_wr | input | 1 | Remote port write (1) or read (0) |
| rem_addr | input | 9 | Remote port byte address |
| rem_wdata | input | DW | Remote port write data |
| rem_rdata | output | DW | Remote port read data, valid the cycle after the read |
| rem_irq | output | 1 | Remote side interrupt |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is an enqueue from one port and a dequeue from the other on the same channel. The bench fills a channel, then in one cycle issues a local data write and a remote data read. It expects the read to return the oldest word, the count to stay at the depth, and the new word to appear last when the FIFO is drained.

The second pair is a write-one-to-clear and a receive-pending bit whose FIFO still holds words. A zero write and an all-ones write are issued around the drain. The bench then reads the status from both the owning side and the peer view, and expects the bit to drop only after the FIFO is empty while the transmit-space bits stay as they were.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int MAX_CH = 16;
    localparam int BUS_AW = 9;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PEER_EN,
        RG_PEER_ST,
        RG_OWN_EN,
        RG_OWN_ST,
        RG_FIFO_ST,
        RG_MSG_CNT,
        RG_DATA
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] ch;
    } reg_sel_t;

    // Map a byte address of either port onto a register kind and channel.
    function automatic reg_sel_t decode_addr(input logic [BUS_AW-1:0] a, input int nch);
        reg_sel_t r;
        r.kind = RG_NONE;
        r.ch   = a[5:2];
        if (a[1:0] == 2'b00) begin
            if (a[8]) begin
                if (int'(a[5:2]) < nch) begin
                    unique case (a[7:6])
                        2'd0:    r.kind = RG_FIFO_ST;
                        2'd1:    r.kind = RG_MSG_CNT;
                        2'd2:    r.kind = RG_DATA;
                        default: r.kind = RG_NONE;
                    endcase
                end
            end else if (a[7:6] == 2'b01 && a[3:2] == 2'b00) begin
                unique case (a[5:4])
                    2'd0:    r.kind = RG_PEER_EN;
                    2'd1:    r.kind = RG_PEER_ST;
                    2'd2:    r.kind = RG_OWN_EN;
                    default: r.kind = RG_OWN_ST;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop);
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst) (full && push && !pop) |=> (count == $past(count))); // R4
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst) (empty && pop && !push) |=> empty); // R4
    AST_FULL_BOTH: assert property (@(posedge clk) disable iff (rst) (full && push && pop) |=> full); // R5

endmodule

// File: rtl/mbox_side.sv
module mbox_side
    import mbox_pkg::*;
#(
    parameter int             NCH     = 8,
    parameter int             DW      = 32,
    parameter int             DEPTH   = 4,
    parameter logic [NCH-1:0] TX_MASK = '0,
    parameter logic [NCH-1:0] RX_MASK = '0,
    localparam int            CW      = $clog2(DEPTH + 1),
    localparam int            CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sel,
    input  logic                         wr,
    input  logic [BUS_AW-1:0]            addr,
    input  logic [DW-1:0]                wdata,
    output logic [DW-1:0]                rdata,
    output logic                         irq,
    output logic [NCH-1:0]               push,
    output logic [NCH-1:0]               pop,
    input  logic [NCH-1:0]               ch_full,
    input  logic [NCH-1:0]               ch_empty,
    input  logic [NCH-1:0][CW-1:0]       ch_count,
    input  logic [NCH-1:0][DW-1:0]       ch_head,
    input  logic [DW-1:0]                peer_en,
    input  logic [DW-1:0]                peer_st,
    output logic [DW-1:0]                own_en,
    output logic [DW-1:0]                own_st
);

    localparam logic [DW-1:0] EN_MASK = DW'((64'(1) << (2 * NCH)) - 64'(1));

    reg_sel_t       rs;
    logic           rd_req, wr_req, clr_hit;
    logic [CHW-1:0] ci;
    logic [NCH-1:0] rx_pend;
    logic [DW-1:0]  rd_next;

    assign rs      = decode_addr(addr, NCH);
    assign ci      = rs.ch[CHW-1:0];
    assign rd_req  = sel && !wr;
    assign wr_req  = sel && wr;
    assign clr_hit = wr_req && (rs.kind == RG_OWN_ST);

    // Per-channel data strobes, gated by channel direction.
    for (genvar n = 0; n < NCH; n++) begin : g_strobe
        assign push[n] = wr_req && (rs.kind == RG_DATA) && (rs.ch == 4'(n)) && TX_MASK[n];
        assign pop[n]  = rd_req && (rs.kind == RG_DATA) && (rs.ch == 4'(n)) && RX_MASK[n];
    end

    // Status word: sticky receive-pending and live transmit-space.
    always_comb begin
        own_st = '0;
        for (int n = 0; n < NCH; n++) begin
            own_st[2*n]   = rx_pend[n];
            own_st[2*n+1] = TX_MASK[n] & ~ch_full[n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_pend <= '0;
        end else begin
            for (int n = 0; n < NCH; n++) begin
                rx_pend[n] <= (rx_pend[n] & ~(clr_hit && wdata[2*n])) | (RX_MASK[n] & ~ch_empty[n]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_en <= '0;
        end else if (wr_req && rs.kind == RG_OWN_EN) begin
            own_en <= wdata & EN_MASK;
        end
    end

    assign irq = |(own_en & own_st);

    always_comb begin
        unique case (rs.kind)
            RG_PEER_EN: rd_next = peer_en;
            RG_PEER_ST: rd_next = peer_st;
            RG_OWN_EN:  rd_next = own_en;
            RG_OWN_ST:  rd_next = own_st;
            RG_FIFO_ST: rd_next = DW'(ch_full[ci]);
            RG_MSG_CNT: rd_next = DW'(ch_count[ci]);
            RG_DATA:    rd_next = (RX_MASK[ci] && !ch_empty[ci]) ? ch_head[ci] : '0;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_req) begin
            rdata <= rd_next;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_chk
        if (RX_MASK[n]) begin : g_rx
            AST_RX_SET: assert property (@(posedge clk) disable iff (rst) !ch_empty[n] |=> own_st[2*n]); // R7
            AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr_hit && wdata[2*n] && ch_empty[n]) |=> !own_st[2*n]); // R8
        end else begin : g_norx
            AST_RX_IDLE: assert property (@(posedge clk) disable iff (rst) !own_st[2*n]); // R7
        end
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst) !(wr_req && rs.kind == RG_OWN_EN) |=> $stable(own_en)); // R9

endmodule

// File: rtl/mailbox_dual.sv
module mailbox_dual
    import mbox_pkg::*;
#(
    parameter int             NCH         = 8,
    parameter int             DEPTH       = 4,
    parameter int             DW          = 32,
    parameter logic [NCH-1:0] LOCAL_SENDS = NCH'({((NCH + 1) / 2){2'b01}}),
    localparam int            CW          = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              loc_sel,
    input  logic              loc_wr,
    input  logic [BUS_AW-1:0] loc_addr,
    input  logic [DW-1:0]     loc_wdata,
    output logic [DW-1:0]     loc_rdata,
    output logic              loc_irq,
    input  logic              rem_sel,
    input  logic              rem_wr,
    input  logic [BUS_AW-1:0] rem_addr,
    input  logic [DW-1:0]     rem_wdata,
    output logic [DW-1:0]     rem_rdata,
    output logic              rem_irq
);

    logic [NCH-1:0]         ch_full, ch_empty;
    logic [NCH-1:0][CW-1:0] ch_count;
    logic [NCH-1:0][DW-1:0] ch_head;
    logic [NCH-1:0][DW-1:0] ch_wdata;
    logic [NCH-1:0]         loc_push, loc_pop, rem_push, rem_pop;
    logic [DW-1:0]          loc_en, loc_st, rem_en, rem_st;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        if (LOCAL_SENDS[n]) begin : g_l2r
            assign ch_wdata[n] = loc_wdata;
        end else begin : g_r2l
            assign ch_wdata[n] = rem_wdata;
        end

        mbox_fifo #(
            .DW    (DW),
            .DEPTH (DEPTH)
        ) i_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (loc_push[n] | rem_push[n]),
            .wdata (ch_wdata[n]),
            .pop   (loc_pop[n] | rem_pop[n]),
            .head  (ch_head[n]),
            .count (ch_count[n]),
            .full  (ch_full[n]),
            .empty (ch_empty[n])
        );
    end

    mbox_side #(
        .NCH     (NCH),
        .DW      (DW),
        .DEPTH   (DEPTH),
        .TX_MASK (LOCAL_SENDS),
        .RX_MASK (~LOCAL_SENDS)
    ) i_loc (
        .clk      (clk),
        .rst      (rst),
        .sel      (loc_sel),
        .wr       (loc_wr),
        .addr     (loc_addr),
        .wdata    (loc_wdata),
        .rdata    (loc_rdata),
        .irq      (loc_irq),
        .push     (loc_push),
        .pop      (loc_pop),
        .ch_full  (ch_full),
        .ch_empty (ch_empty),
        .ch_count (ch_count),
        .ch_head  (ch_head),
        .peer_en  (rem_en),
        .peer_st  (rem_st),
        .own_en   (loc_en),
        .own_st   (loc_st)
    );

    mbox_side #(
        .NCH     (NCH),
        .DW      (DW),
        .DEPTH   (DEPTH),
        .TX_MASK (~LOCAL_SENDS),
        .RX_MASK (LOCAL_SENDS)
    ) i_rem (
        .clk      (clk),
        .rst      (rst),
        .sel      (rem_sel),
        .wr       (rem_wr),
        .addr     (rem_addr),
        .wdata    (rem_wdata),
        .rdata    (rem_rdata),
        .irq      (rem_irq),
        .push     (rem_push),
        .pop      (rem_pop),
        .ch_full  (ch_full),
        .ch_empty (ch_empty),
        .ch_count (ch_count),
        .ch_head  (ch_head),
        .peer_en  (loc_en),
        .peer_st  (loc_st),
        .own_en   (rem_en),
        .own_st   (rem_st)
    );

endmodule

// File: tb/test_mailbox_dual.sv
module test_mailbox_dual;

    localparam int CLK_PERIOD = 10;
    localparam logic [8:0] A_PEER_EN = 9'h040;
    localparam logic [8:0] A_PEER_ST = 9'h050;
    localparam logic [8:0] A_OWN_EN  = 9'h060;
    localparam logic [8:0] A_OWN_ST  = 9'h070;
    localparam logic [8:0] A_FST0    = 9'h100;
    localparam logic [8:0] A_CNT0    = 9'h140;
    localparam logic [8:0] A_DAT0    = 9'h180;
    localparam logic [8:0] A_DAT3    = 9'h18C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        loc_sel = 1'b0, loc_wr = 1'b0, rem_sel = 1'b0, rem_wr = 1'b0;
    logic [8:0]  loc_addr = '0, rem_addr = '0;
    logic [31:0] loc_wdata = '0, rem_wdata = '0;
    logic [31:0] loc_rdata, rem_rdata;
    logic        loc_irq, rem_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] exp_l[$], exp_r[$];
    string       tag_l[$], tag_r[$];
    logic        mon_l = 1'b0, mon_r = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mailbox_dual i_mailbox_dual (
        .clk(clk), .rst(rst),
        .loc_sel(loc_sel), .loc_wr(loc_wr), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata), .loc_irq(loc_irq),
        .rem_sel(rem_sel), .rem_wr(rem_wr), .rem_addr(rem_addr), .rem_wdata(rem_wdata),
        .rem_rdata(rem_rdata), .rem_irq(rem_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Monitor: a read issued at a rising edge is compared at the following falling edge.
    always @(posedge clk) begin
        mon_l <= loc_sel && !loc_wr;
        mon_r <= rem_sel && !rem_wr;
    end

    always @(negedge clk) begin
        if (mon_l && exp_l.size() > 0) chk(tag_l.pop_front(), loc_rdata, exp_l.pop_front());
        if (mon_r && exp_r.size() > 0) chk(tag_r.pop_front(), rem_rdata, exp_r.pop_front());
    end

    task automatic lwr(input logic [8:0] a, input logic [31:0] d);
        loc_sel = 1'b1; loc_wr = 1'b1; loc_addr = a; loc_wdata = d;
    endtask

    task automatic rwr(input logic [8:0] a, input logic [31:0] d);
        rem_sel = 1'b1; rem_wr = 1'b1; rem_addr = a; rem_wdata = d;
    endtask

    task automatic lrd(input logic [8:0] a, input logic [31:0] e, input string t);
        loc_sel = 1'b1; loc_wr = 1'b0; loc_addr = a;
        exp_l.push_back(e); tag_l.push_back(t);
    endtask

    task automatic rrd(input logic [8:0] a, input logic [31:0] e, input string t);
        rem_sel = 1'b1; rem_wr = 1'b0; rem_addr = a;
        exp_r.push_back(e); tag_r.push_back(t);
    endtask

    task automatic cyc();
        @(negedge clk);
        loc_sel = 1'b0;
        rem_sel = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 loc_rdata", loc_rdata, 32'h0);
        chk("R1 rem_rdata", rem_rdata, 32'h0);
        chk("R1 loc_irq", 32'(loc_irq), 32'h0);
        chk("R1 rem_irq", 32'(rem_irq), 32'h0);
        // R11 default directions: local tx on even channels, remote on odd
        lrd(A_OWN_ST, 32'h0000_2222, "R11 local status"); rrd(A_OWN_ST, 32'h0000_8888, "R11 remote status"); cyc();
        lrd(A_PEER_ST, 32'h0000_8888, "R9 peer status"); rrd(A_OWN_EN, 32'h0, "R1 enable"); cyc();
        rrd(A_CNT0, 32'h0, "R1 count"); cyc();

        // R2 fill channel 0 from local
        for (int i = 0; i < 4; i++) begin
            lwr(A_DAT0, 32'hA0 + 32'(i)); cyc();
        end
        cyc();
        rrd(A_CNT0, 32'd4, "R3 count full"); lrd(A_FST0, 32'd1, "R3 full flag"); cyc();
        rrd(A_OWN_ST, 32'h0000_8889, "R7 rx pending"); lrd(A_OWN_ST, 32'h0000_2220, "R7 tx space gone"); cyc();
        // R4 write to full dropped
        lwr(A_DAT0, 32'hDEAD); cyc();
        rrd(A_CNT0, 32'd4, "R4 drop count"); cyc();
        // R10 enable interrupt
        rwr(A_OWN_EN, 32'h1); cyc();
        chk("R10 rem_irq set", 32'(rem_irq), 32'h1);
        chk("R10 loc_irq clear", 32'(loc_irq), 32'h0);

        // R5 simultaneous enqueue and dequeue on full FIFO
        rrd(A_DAT0, 32'hA0, "R5 oldest out"); lwr(A_DAT0, 32'hB0); cyc();
        rrd(A_CNT0, 32'd4, "R5 count held"); cyc();
        rrd(A_FST0, 32'd1, "R5 still full"); cyc();
        // R2 drain in order
        rrd(A_DAT0, 32'hA1, "R2 order 1"); cyc();
        rrd(A_DAT0, 32'hA2, "R2 order 2"); cyc();
        rrd(A_DAT0, 32'hA3, "R2 order 3"); cyc();
        rrd(A_DAT0, 32'hB0, "R2 order 4"); cyc();
        rrd(A_DAT0, 32'h0, "R4 empty read"); cyc();
        rrd(A_CNT0, 32'h0, "R4 empty count"); cyc();

        // R8 sticky pending, ack seen by peer
        rrd(A_OWN_ST, 32'h0000_8889, "R8 sticky"); lrd(A_PEER_ST, 32'h0000_8889, "R9 not acked"); cyc();
        chk("R10 irq while pending", 32'(rem_irq), 32'h1);
        rwr(A_OWN_ST, 32'h0); cyc();
        rrd(A_OWN_ST, 32'h0000_8889, "R8 zero write"); cyc();
        rwr(A_OWN_ST, 32'hFFFF_FFFF); cyc();
        rrd(A_OWN_ST, 32'h0000_8888, "R8 cleared tx kept"); lrd(A_PEER_ST, 32'h0000_8888, "R9 acked"); cyc();
        chk("R10 rem_irq dropped", 32'(rem_irq), 32'h0);

        // R6 wrong-side accesses
        rwr(A_DAT0, 32'h1234); cyc();
        rrd(A_CNT0, 32'h0, "R6 wrong-side write"); cyc();
        lwr(A_DAT0, 32'h55); cyc();
        lrd(A_DAT0, 32'h0, "R6 wrong-side read"); cyc();
        lrd(A_CNT0, 32'd1, "R6 count kept"); cyc();
        rrd(A_DAT0, 32'h55, "R2 word intact"); cyc();

        // R9 peer view is read-only
        lwr(A_PEER_EN, 32'hFFFF_FFFF); cyc();
        rrd(A_OWN_EN, 32'h1, "R9 peer write ignored"); lrd(A_PEER_EN, 32'h1, "R9 peer enable view"); cyc();

        // R7 / R10 odd channel from remote to local
        rwr(A_DAT3, 32'h77); cyc();
        cyc();
        lrd(A_OWN_ST, 32'h0000_2262, "R7 rx bit 2n"); cyc();
        lwr(A_OWN_EN, 32'h40); cyc();
        chk("R10 loc_irq set", 32'(loc_irq), 32'h1);
        lrd(A_DAT3, 32'h77, "R2 odd channel"); cyc();
        lwr(A_OWN_ST, 32'h40); cyc();
        cyc();
        chk("R10 loc_irq cleared", 32'(loc_irq), 32'h0);
        lrd(A_OWN_ST, 32'h0000_2222, "R8 local clear"); cyc();

        repeat (3) @(negedge clk);
        done = 1;
        report();
    end

endmodule